// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it may accept one operation. The operation comes with the accumulator value, one operand byte and the current five-bit flag word. The operand byte may have come from a register, from memory or from immediate data, but it is fetched outside this block. One clock edge later the block presents the result byte, the new flag word and two write strobes. The accumulator strobe marks results that go back to the accumulator. The target strobe marks increment and decrement results, which go back to the location their operand came from.

The block covers several groups of operations:
- Byte arithmetic: plain add and subtract, plus the variants that take carry or borrow in.
- Bitwise operations: AND, XOR and OR.
- A flags-only compare.
- Single-step increment and decrement.
- Accumulator complement.
- Carry-flag set and carry-flag invert.
- Four one-bit rotates: two copy the moved bit into carry, and two rotate through carry.

Every group follows its own rules for carry and auxiliary carry. The flag word is always returned in full, so operations that touch no flag pass the incoming word through unchanged.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on op_i are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 complement accumulator, 11 set carry, 12 invert carry, 13 rotate left, 14 rotate right, 15 rotate left through carry, 16 rotate right through carry, 17 no-op. The flag word is {S,Z,AC,P,CY}, with CY in bit 0 and S in bit 4. Results appear one clock after valid_i, marked by valid_o. At most one write strobe is high at a time, and reset clears every output to zero.
- R2: Add computes acc+opnd, and add-with-carry computes acc+opnd+CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. The accumulator is written.
- R3: Subtract computes acc-opnd, and subtract-with-borrow computes acc-opnd-CY. CY is 1 when a borrow leaves bit 7, and AC is 1 when the low nibble needs a borrow. The accumulator is written.
- R4: Compare sets all flags exactly as subtract does and shows the difference on res_o, but acc_we_o stays 0. Equal operands give Z=1 and CY=0, and acc below opnd gives CY=1.
- R5: AND writes acc&opnd and forces CY=0 and AC=1.
- R6: XOR and OR write their result and force both CY and AC to 0.
- R7: For operation codes 0 through 9, S is result bit 7, Z is 1 when the result is zero, and P is 1 when the result has an even number of one bits.
- R8: Increment computes opnd+1 and decrement computes opnd-1. The result is flagged with dst_we_o, not acc_we_o. CY is carried through unchanged. AC is the carry out of bit 3 for increment and the low-nibble borrow for decrement.
- R9: Complement accumulator writes ~acc and leaves all five flags unchanged.
- R10: Set carry forces CY to 1 and invert carry flips CY. Both leave the other flags unchanged, show acc on res_o and write nothing.
- R11: Rotate left moves bit 7 into both bit 0 and CY. Rotate right moves bit 0 into both bit 7 and CY. The accumulator is written and only CY changes among the flags.
- R12: Rotate left through carry shifts old CY into bit 0 and bit 7 into CY. Rotate right through carry shifts old CY into bit 7 and bit 0 into CY. The accumulator is written and only CY changes among the flags.
- R13: The no-op code and codes 18 to 31 write nothing, show acc on res_o and return the flags unchanged. A cycle with valid_i low gives valid_o=0 and both strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Operand byte (register, memory or immediate) |
| flags_i | input | 5 | Current flags {S,Z,AC,P,CY} |
| valid_o | output | 1 | Result valid |
| res_o | output | 8 | Result byte |
| flags_o | output | 5 | New flags {S,Z,AC,P,CY} |
| acc_we_o | output | 1 | Write res_o to the accumulator |
| dst_we_o | output | 1 | Write res_o back to the operand's location |

## Verification
Two parts of the block can act on one operation in the same cycle: the shared adder's carry chain and the zero/parity generator. An add-with-carry of 0xFF and 0x00 with CY=1 wraps to zero, which provokes both at once. It must raise CY, AC, Z and P together, and the bench compares the whole flag word against a hand-computed value. A second overlap comes from increment and decrement. They drive the same adder and the same S/Z/P logic, but they must carry CY through untouched. This is judged by applying them with CY set and with CY clear, and by a property tying the output CY to the input CY on those codes. A reference model inside the bench also covers random operands, both carry-in values and the unused codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned OP_W = 5;
  localparam int unsigned FL_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_AND = 5'd4,
    OP_XOR = 5'd5,
    OP_OR  = 5'd6,
    OP_CMP = 5'd7,
    OP_INC = 5'd8,
    OP_DEC = 5'd9,
    OP_CMA = 5'd10,
    OP_STC = 5'd11,
    OP_CMC = 5'd12,
    OP_RLC = 5'd13,
    OP_RRC = 5'd14,
    OP_RAL = 5'd15,
    OP_RAR = 5'd16,
    OP_NOP = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,  // carry in for add, borrow in for subtract
  output logic [DW-1:0] sum_o,
  output logic          cy_o,   // carry out for add, borrow out for subtract
  output logic          ac_o
);
  localparam int unsigned NIB = DW / 2;

  logic [DW-1:0] b_x;
  logic          c0;
  logic [DW:0]   full;
  logic [NIB:0]  low;

  // subtract as a + ~b + ~borrow; invert the carries back into borrows
  assign b_x  = sub_i ? ~b_i : b_i;
  assign c0   = sub_i ? ~cin_i : cin_i;
  assign full = {1'b0, a_i} + {1'b0, b_x} + {{DW{1'b0}}, c0};
  assign low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_x[NIB-1:0]} + {{NIB{1'b0}}, c0};

  assign sum_o = full[DW-1:0];
  assign cy_o  = full[DW] ^ sub_i;
  assign ac_o  = low[NIB] ^ sub_i;
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_CMA: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_szp.sv
module alu_szp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] res_i,
  output logic          s_o,
  output logic          z_o,
  output logic          p_o
);
  assign s_o = res_i[DW-1];
  assign z_o = (res_i == '0);
  assign p_o = ~^res_i;  // even count of ones
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [FL_W-1:0] flags_i,
  output logic            valid_o,
  output logic [DW-1:0]   res_o,
  output logic [FL_W-1:0] flags_o,
  output logic            acc_we_o,
  output logic            dst_we_o
);
  alu_op_e    op;
  alu_flags_t fl_in, fl_nx;
  logic       is_step, is_sub, use_cy;

  logic [DW-1:0] add_a, add_b, add_sum, bit_res, res_nx;
  logic          add_cin, add_cy, add_ac, bit_cy;
  logic          szp_s, szp_z, szp_p, awe_nx, dwe_nx;

  assign op    = alu_op_e'(op_i);
  assign fl_in = alu_flags_t'(flags_i);

  assign is_step = (op == OP_INC) || (op == OP_DEC);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_DEC);
  assign use_cy  = (op == OP_ADC) || (op == OP_SBB);

  // step ops run opnd +/- 1 through the shared adder
  assign add_a   = is_step ? opnd_i : acc_i;
  assign add_b   = is_step ? '0 : opnd_i;
  assign add_cin = is_step ? 1'b1 : (use_cy & fl_in.cy);

  alu_addsub #(.DW(DW)) u_addsub (
    .a_i   (add_a),
    .b_i   (add_b),
    .sub_i (is_sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cy_o  (add_cy),
    .ac_o  (add_ac)
  );

  alu_bitops #(.DW(DW)) u_bitops (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (fl_in.cy),
    .res_o (bit_res),
    .cy_o  (bit_cy)
  );

  alu_szp #(.DW(DW)) u_szp (
    .res_i (res_nx),
    .s_o   (szp_s),
    .z_o   (szp_z),
    .p_o   (szp_p)
  );

  always_comb begin
    res_nx = acc_i;
    fl_nx  = fl_in;
    awe_nx = 1'b0;
    dwe_nx = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res_nx   = add_sum;
        fl_nx.cy = add_cy;
        fl_nx.ac = add_ac;
        awe_nx   = (op != OP_CMP);
      end
      OP_INC, OP_DEC: begin
        res_nx   = add_sum;
        fl_nx.ac = add_ac;
        dwe_nx   = 1'b1;
      end
      OP_AND: begin
        res_nx   = bit_res;
        fl_nx.cy = 1'b0;
        fl_nx.ac = 1'b1;
        awe_nx   = 1'b1;
      end
      OP_XOR, OP_OR: begin
        res_nx   = bit_res;
        fl_nx.cy = 1'b0;
        fl_nx.ac = 1'b0;
        awe_nx   = 1'b1;
      end
      OP_CMA: begin
        res_nx = bit_res;
        awe_nx = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_nx   = bit_res;
        fl_nx.cy = bit_cy;
        awe_nx   = 1'b1;
      end
      OP_STC: fl_nx.cy = 1'b1;
      OP_CMC: fl_nx.cy = ~fl_in.cy;
      default: ;
    endcase
    // S/Z/P follow the result for the arithmetic and logic groups
    if (op_i <= OP_DEC) begin
      fl_nx.s = szp_s;
      fl_nx.z = szp_z;
      fl_nx.p = szp_p;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      acc_we_o <= 1'b0;
      dst_we_o <= 1'b0;
      res_o    <= '0;
      flags_o  <= '0;
    end else begin
      valid_o  <= valid_i;
      acc_we_o <= valid_i & awe_nx;
      dst_we_o <= valid_i & dwe_nx;
      if (valid_i) begin
        res_o   <= res_nx;
        flags_o <= fl_nx;
      end
    end
  end

  // R1
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_we_o && dst_we_o));

  // R4
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |=> (valid_o && !acc_we_o && !dst_we_o));

  // R4
  cmp_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP && acc_i == opnd_i) |=> (flags_o[3] && !flags_o[0]));

  // R5
  and_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_AND) |=> (!flags_o[0] && flags_o[2]));

  // R8
  step_cy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_i[0]) && dst_we_o));

  // R11
  rlc_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_RLC) |=> (res_o[0] == flags_o[0] && flags_o[0] == $past(acc_i[DW-1])));

  // R13
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !acc_we_o && !dst_we_o));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic [4:0] flags_i = '0;
  logic       valid_o, acc_we_o, dst_we_o;
  logic [7:0] res_o;
  logic [4:0] flags_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  acc_alu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i), .valid_o(valid_o),
    .res_o(res_o), .flags_o(flags_o), .acc_we_o(acc_we_o), .dst_we_o(dst_we_o)
  );

  // {op, acc, opnd, flags_in, exp_res, exp_flags, exp_acc_we, exp_dst_we}
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {5'd0,  8'h20, 8'h30, 5'b00000, 8'h50, 5'b00010, 1'b1, 1'b0},
    {5'd1,  8'hFF, 8'h00, 5'b00001, 8'h00, 5'b01111, 1'b1, 1'b0},
    {5'd2,  8'h50, 8'h30, 5'b00000, 8'h20, 5'b00000, 1'b1, 1'b0},
    {5'd3,  8'h40, 8'h20, 5'b00001, 8'h1F, 5'b00100, 1'b1, 1'b0},
    {5'd2,  8'h10, 8'h20, 5'b00000, 8'hF0, 5'b10011, 1'b1, 1'b0},
    {5'd7,  8'hB8, 8'hB8, 5'b00000, 8'h00, 5'b01010, 1'b0, 1'b0},
    {5'd7,  8'h10, 8'h20, 5'b00000, 8'hF0, 5'b10011, 1'b0, 1'b0},
    {5'd4,  8'hAA, 8'h0F, 5'b00001, 8'h0A, 5'b00110, 1'b1, 1'b0},
    {5'd5,  8'hAA, 8'h2D, 5'b00101, 8'h87, 5'b10010, 1'b1, 1'b0},
    {5'd6,  8'hAA, 8'h12, 5'b00101, 8'hBA, 5'b10000, 1'b1, 1'b0},
    {5'd8,  8'h55, 8'h0F, 5'b00001, 8'h10, 5'b00101, 1'b0, 1'b1},
    {5'd9,  8'h55, 8'h00, 5'b00000, 8'hFF, 5'b10110, 1'b0, 1'b1},
    {5'd9,  8'h55, 8'h01, 5'b00001, 8'h00, 5'b01011, 1'b0, 1'b1},
    {5'd10, 8'h55, 8'h00, 5'b10101, 8'hAA, 5'b10101, 1'b1, 1'b0},
    {5'd11, 8'h33, 8'h00, 5'b11010, 8'h33, 5'b11011, 1'b0, 1'b0},
    {5'd12, 8'h00, 8'h00, 5'b00001, 8'h00, 5'b00000, 1'b0, 1'b0},
    {5'd13, 8'h95, 8'h00, 5'b11110, 8'h2B, 5'b11111, 1'b1, 1'b0},
    {5'd14, 8'h95, 8'h00, 5'b00000, 8'hCA, 5'b00001, 1'b1, 1'b0},
    {5'd15, 8'h95, 8'h00, 5'b00000, 8'h2A, 5'b00001, 1'b1, 1'b0},
    {5'd16, 8'h94, 8'h00, 5'b00001, 8'hCA, 5'b00000, 1'b1, 1'b0},
    {5'd17, 8'h12, 8'h77, 5'b10101, 8'h12, 5'b10101, 1'b0, 1'b0},
    {5'd25, 8'h34, 8'h77, 5'b01010, 8'h34, 5'b01010, 1'b0, 1'b0}
  };

  function automatic string req_of(input int op);
    case (op)
      0, 1:           return "R2";
      2, 3:           return "R3";
      7:              return "R4";
      4:              return "R5";
      5, 6:           return "R6";
      8, 9:           return "R8";
      10:             return "R9";
      11, 12:         return "R10";
      13, 14:         return "R11";
      15, 16:         return "R12";
      default:        return "R13";
    endcase
  endfunction

  // independent model: {res, flags, acc_we, dst_we}
  function automatic logic [14:0] ref_calc(input int op, input logic [7:0] a, input logic [7:0] b,
                                           input logic [4:0] f);
    logic [7:0] r;
    logic [4:0] o;
    logic aw, dw, cy;
    int t, lo, ci;
    cy = f[0]; r = a; o = f; aw = 1'b0; dw = 1'b0;
    ci = int'(cy);
    case (op)
      0, 1: begin
        t  = int'(a) + int'(b) + ((op == 1) ? ci : 0);
        lo = int'(a[3:0]) + int'(b[3:0]) + ((op == 1) ? ci : 0);
        r = t[7:0]; o[0] = (t > 255); o[2] = (lo > 15); aw = 1'b1;
      end
      2, 3, 7: begin
        t  = int'(a) - int'(b) - ((op == 3) ? ci : 0);
        lo = int'(a[3:0]) - int'(b[3:0]) - ((op == 3) ? ci : 0);
        r = t[7:0]; o[0] = (t < 0); o[2] = (lo < 0); aw = (op != 7);
      end
      4: begin r = a & b; o[0] = 1'b0; o[2] = 1'b1; aw = 1'b1; end
      5: begin r = a ^ b; o[0] = 1'b0; o[2] = 1'b0; aw = 1'b1; end
      6: begin r = a | b; o[0] = 1'b0; o[2] = 1'b0; aw = 1'b1; end
      8: begin r = b + 8'd1; o[2] = (b[3:0] == 4'hF); dw = 1'b1; end
      9: begin r = b - 8'd1; o[2] = (b[3:0] == 4'h0); dw = 1'b1; end
      10: begin r = ~a; aw = 1'b1; end
      11: o[0] = 1'b1;
      12: o[0] = ~cy;
      13: begin r = {a[6:0], a[7]}; o[0] = a[7]; aw = 1'b1; end
      14: begin r = {a[0], a[7:1]}; o[0] = a[0]; aw = 1'b1; end
      15: begin r = {a[6:0], cy};   o[0] = a[7]; aw = 1'b1; end
      16: begin r = {cy, a[7:1]};   o[0] = a[0]; aw = 1'b1; end
      default: ;
    endcase
    if (op <= 9) begin
      o[4] = r[7]; o[3] = (r == 8'h00); o[1] = ~^r;
    end
    return {r, o, aw, dw};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] b,
                        input logic [4:0] f, input logic [14:0] exp);
    string rq;
    rq = req_of(op);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op[4:0]; acc_i = a; opnd_i = b; flags_i = f;
    @(negedge clk_i);
    check("R1", "valid", 32'(valid_o), 32'd1);
    check(rq, "res", 32'(res_o), 32'(exp[14:7]));
    check(rq, "flags", 32'(flags_o), 32'(exp[6:2]));
    check(rq, "acc_we", 32'(acc_we_o), 32'(exp[1]));
    check(rq, "dst_we", 32'(dst_we_o), 32'(exp[0]));
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "rst valid", 32'(valid_o), 0);
    check("R1", "rst res", 32'(res_o), 0);
    check("R1", "rst flags", 32'(flags_o), 0);
    check("R1", "rst we", 32'({acc_we_o, dst_we_o}), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      run_op(int'(v[40:36]), v[35:28], v[27:20], v[19:15], v[14:0]);
    end

    // R7: model cross-check; wrap-to-zero corner first
    run_op(1, 8'hFF, 8'h00, 5'b00001, ref_calc(1, 8'hFF, 8'h00, 5'b00001));
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] a, b;
      logic [4:0] f;
      op = $urandom_range(0, 19);
      a = 8'($urandom); b = 8'($urandom); f = 5'($urandom);
      run_op(op, a, b, f, ref_calc(op, a, b, f));
    end

    // R13: idle cycle writes nothing
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 5'd0; acc_i = 8'h11; opnd_i = 8'h22;
    @(negedge clk_i);
    check("R13", "idle valid", 32'(valid_o), 0);
    check("R13", "idle we", 32'({acc_we_o, dst_we_o}), 0);

    // R1: reset mid-run clears outputs
    run_op(4, 8'hFF, 8'hFF, 5'b00000, ref_calc(4, 8'hFF, 8'hFF, 5'b00000));
    rst_ni = 1'b0;
    #1;
    check("R1", "async rst res", 32'(res_o), 0);
    check("R1", "async rst flags", 32'(flags_o), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule